// File: doc/BRIEF.md
# Grouped-Frequency Twelve-Channel PWM Controller

This block drives twelve output pins. Each pin is either a pulse-width modulated wave or a static level held in a register. The channels form three fixed groups of four. Each group has one frequency word in pulses per second, so three frequencies can run at once. Each channel has its own duty word in tenths of a percent. A host programs the block through a single-cycle write port made of address, data and strobe. Every register can be read back through a combinational read port on the same address.

Each group generates its period with a phase accumulator. On every clock the accumulator adds the group's frequency and wraps at `CLK_HZ`. The wrap marks a period boundary. At that boundary each channel loads its threshold, computed as duty × (`CLK_HZ`/1000). The channel's PWM level is high while the accumulator sits below that threshold. Duty ramping is done by a separate block that writes effective values into this one.

An error register records the last rejected or clamped write. Software clears it by writing zero to it.

Top module: `pwm_grouped`

## Requirements
- R1: During and after a synchronous active-low reset, every output is low and the control, level, frequency, duty and error registers all read 0.
- R2: Register 0x00 is the mode word. Bit n set means channel n+1 outputs PWM, and bit n clear means channel n+1 outputs bit n of the level register at 0x04. Bits 12..15 of the mode word are neither stored nor read back.
- R3: Registers 0x01, 0x02 and 0x03 hold the frequencies of channels 1-4, 5-8 and 9-12. When f divides `CLK_HZ`, a group running at f repeats every `CLK_HZ`/f clocks. A new frequency changes the accumulator step on the next clock.
- R4: Registers 0x0A..0x15 hold the duty of channels 1..12. Each period has ceil(d·(`CLK_HZ`/1000)/f) high clocks. A duty of 0 gives a constant low level and a duty of 1000 gives a constant high level.
- R5: A frequency of 0 holds the group's PWM levels low and parks its accumulator at 0. After a restart, the first boundary comes `CLK_HZ`/f clocks after the write.
- R6: While a group runs, a duty write does not change the output until the group's next period boundary, so no period is cut short.
- R7: A frequency write above `FREQ_MAX` is discarded and sets the error register to 1.
- R8: A duty write above 1000 stores 1000 and sets the error register to 2.
- R9: The error register is at 0x09. Writing 0 to it clears it, and any other write to it is ignored.
- R10: Address 0x3F returns `VERSION` and ignores writes. Every unlisted address reads 0, and writes to it change nothing.
- R11: Each output pin is registered, so a change of mode, level or PWM level appears one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| addr | input | 6 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pwm_out | output | NGRP*GRP_SZ | Registered channel outputs |

## Verification
A duty write and a period boundary can land in the same cycle. The bench restarts a stopped group at a known cycle, so the clock of every later wrap is known. It then writes a new duty partway through the first period and checks that the pin keeps its old level through the boundary clock. The pin must take the new level exactly one registered stage after the boundary. A second overlap is between an out-of-range write and the error register's own clear. The bench checks that the error code survives a nonzero write to 0x09 and is cleared only by zero.

// File: rtl/pwm_grp_pkg.sv
// Shared constants and types for the grouped PWM controller.
// Assumes a 6-bit register address space and 16-bit data words.
package pwm_grp_pkg;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 16;
    localparam int DUTY_W    = 10;
    localparam int DUTY_FULL = 1000;

    localparam logic [ADDR_W-1:0] A_MODE  = 6'h00;
    localparam logic [ADDR_W-1:0] A_FREQ0 = 6'h01;
    localparam logic [ADDR_W-1:0] A_LEVEL = 6'h04;
    localparam logic [ADDR_W-1:0] A_ERR   = 6'h09;
    localparam logic [ADDR_W-1:0] A_DUTY0 = 6'h0A;
    localparam logic [ADDR_W-1:0] A_VER   = 6'h3F;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_FREQ = 2'd1,
        ERR_DUTY = 2'd2
    } err_e;
endpackage

// File: rtl/pwm_grp_regs.sv
// Register bank: write decode, range checks, error code and read mux.
// Assumes A_FREQ0+NGRP <= A_LEVEL and A_DUTY0+NCH <= A_VER.
module pwm_grp_regs
    import pwm_grp_pkg::*;
#(
    parameter int NGRP     = 3,
    parameter int NCH      = 12,
    parameter int FREQ_MAX = 4000,
    parameter logic [15:0] VERSION = 16'h0102
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NCH-1:0]               mode_q,
    output logic [NCH-1:0]               level_q,
    output logic [NGRP-1:0][DATA_W-1:0]  freq_q,
    output logic [NCH-1:0][DUTY_W-1:0]   duty_q,
    output err_e                         err_q
);
    logic freq_bad;
    logic duty_bad;

    // Range checks on incoming data, shared by every group and channel.
    always_comb begin
        freq_bad = wdata > DATA_W'(FREQ_MAX);
        duty_bad = wdata > DATA_W'(DUTY_FULL);
    end

    // Register storage with discard and clamp handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            level_q <= '0;
            freq_q  <= '0;
            duty_q  <= '0;
            err_q   <= ERR_NONE;
        end else if (wr_en) begin
            if (addr == A_MODE)  mode_q  <= wdata[NCH-1:0];
            if (addr == A_LEVEL) level_q <= wdata[NCH-1:0];
            if (addr == A_ERR && wdata == '0) err_q <= ERR_NONE;
            for (int g = 0; g < NGRP; g++) begin
                if (addr == ADDR_W'(A_FREQ0 + g)) begin
                    if (freq_bad) err_q     <= ERR_FREQ;
                    else          freq_q[g] <= wdata;
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (addr == ADDR_W'(A_DUTY0 + c)) begin
                    if (duty_bad) begin
                        duty_q[c] <= DUTY_W'(DUTY_FULL);
                        err_q     <= ERR_DUTY;
                    end else begin
                        duty_q[c] <= wdata[DUTY_W-1:0];
                    end
                end
            end
        end
    end

    // Read mux; unlisted addresses fall through to zero.
    always_comb begin
        rdata = '0;
        if (addr == A_MODE)  rdata = DATA_W'(mode_q);
        if (addr == A_LEVEL) rdata = DATA_W'(level_q);
        if (addr == A_ERR)   rdata = DATA_W'(err_q);
        if (addr == A_VER)   rdata = VERSION;
        for (int g = 0; g < NGRP; g++)
            if (addr == ADDR_W'(A_FREQ0 + g)) rdata = freq_q[g];
        for (int c = 0; c < NCH; c++)
            if (addr == ADDR_W'(A_DUTY0 + c)) rdata = DATA_W'(duty_q[c]);
    end
endmodule

// File: rtl/pwm_grp_group.sv
// One frequency group: a phase accumulator shared by GRP_SZ channels,
// each with a threshold latched at the period boundary.
// Assumes CLK_HZ is a multiple of 1000 and freq <= FREQ_MAX.
module pwm_grp_group
    import pwm_grp_pkg::*;
#(
    parameter int GRP_SZ   = 4,
    parameter int CLK_HZ   = 50_000_000,
    parameter int FREQ_MAX = 4000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [DATA_W-1:0]              freq,
    input  logic [GRP_SZ-1:0][DUTY_W-1:0]  duty,
    output logic [GRP_SZ-1:0]              pwm_raw
);
    localparam int ACC_W  = $clog2(CLK_HZ + FREQ_MAX + 1);
    localparam int STEP   = CLK_HZ / DUTY_FULL;
    localparam int PROD_W = ACC_W + DUTY_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             run;
    logic             wrap;

    // Next phase and boundary detection.
    always_comb begin
        run  = freq != '0;
        sum  = acc_q + ACC_W'(freq);
        wrap = sum >= ACC_W'(CLK_HZ);
    end

    // Phase accumulator; parked at zero while the group is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (!run)  acc_q <= '0;
        else if (wrap)  acc_q <= sum - ACC_W'(CLK_HZ);
        else            acc_q <= sum;
    end

    for (genvar i = 0; i < GRP_SZ; i++) begin : g_ch
        logic [PROD_W-1:0] prod;
        logic [ACC_W-1:0]  thr_q;

        // Threshold from the duty word, scaled to accumulator units.
        always_comb prod = PROD_W'(duty[i]) * PROD_W'(STEP);

        // Threshold reloads only at a boundary or while stopped.
        always_ff @(posedge clk) begin
            if (!rst_n)             thr_q <= '0;
            else if (!run || wrap)  thr_q <= ACC_W'(prod);
        end

        // Level is high during the leading part of the phase.
        always_comb pwm_raw[i] = run && (acc_q < thr_q);
    end
endmodule

// File: rtl/pwm_grp_outsel.sv
// Output stage: per channel choice between PWM level and static level,
// registered so the pins never glitch. Assumes nothing about the inputs.
module pwm_grp_outsel #(
    parameter int NCH = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] mode,
    input  logic [NCH-1:0] level,
    input  logic [NCH-1:0] pwm_raw,
    output logic [NCH-1:0] pins
);
    // Registered mux per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) pins <= '0;
        else        pins <= (mode & pwm_raw) | (~mode & level);
    end
endmodule

// File: rtl/pwm_grouped.sv
// Top: register bank, NGRP frequency groups of GRP_SZ channels, and
// the registered output stage. Assumes single-cycle host writes.
module pwm_grouped
    import pwm_grp_pkg::*;
#(
    parameter int NGRP     = 3,
    parameter int GRP_SZ   = 4,
    parameter int CLK_HZ   = 50_000_000,
    parameter int FREQ_MAX = 4000,
    parameter logic [15:0] VERSION = 16'h0102
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [5:0]               addr,
    input  logic [15:0]              wdata,
    output logic [15:0]              rdata,
    output logic [NGRP*GRP_SZ-1:0]   pwm_out
);
    localparam int NCH = NGRP * GRP_SZ;

    logic [NCH-1:0]              mode_q;
    logic [NCH-1:0]              level_q;
    logic [NGRP-1:0][DATA_W-1:0] freq_q;
    logic [NCH-1:0][DUTY_W-1:0]  duty_q;
    err_e                        err_q;
    logic [NCH-1:0]              pwm_raw;

    pwm_grp_regs #(
        .NGRP(NGRP), .NCH(NCH), .FREQ_MAX(FREQ_MAX), .VERSION(VERSION)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .mode_q(mode_q), .level_q(level_q),
        .freq_q(freq_q), .duty_q(duty_q), .err_q(err_q)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pwm_grp_group #(
            .GRP_SZ(GRP_SZ), .CLK_HZ(CLK_HZ), .FREQ_MAX(FREQ_MAX)
        ) u_group (
            .clk(clk), .rst_n(rst_n), .freq(freq_q[g]),
            .duty(duty_q[g*GRP_SZ +: GRP_SZ]),
            .pwm_raw(pwm_raw[g*GRP_SZ +: GRP_SZ])
        );
    end

    pwm_grp_outsel #(.NCH(NCH)) u_out (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .level(level_q),
        .pwm_raw(pwm_raw), .pins(pwm_out)
    );
endmodule

// File: rtl/pwm_grouped_chk.sv
// Assertion checker bound into pwm_grouped; observes writes, the
// register bank state and the raw group levels.
module pwm_grouped_chk
    import pwm_grp_pkg::*;
#(
    parameter int NGRP     = 3,
    parameter int GRP_SZ   = 4,
    parameter int FREQ_MAX = 4000
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              wr_en,
    input logic [ADDR_W-1:0]                 addr,
    input logic [DATA_W-1:0]                 wdata,
    input logic [1:0]                        err_q,
    input logic [NGRP-1:0][DATA_W-1:0]       freq_q,
    input logic [NGRP*GRP_SZ-1:0][DUTY_W-1:0] duty_q,
    input logic [NGRP*GRP_SZ-1:0]            pwm_raw
);
    localparam int NCH = NGRP * GRP_SZ;

    logic is_freq, is_duty, is_known, duty_ok;

    // Address classes and duty range summary.
    always_comb begin
        is_freq = (int'(addr) >= int'(A_FREQ0)) && (int'(addr) < int'(A_FREQ0) + NGRP);
        is_duty = (int'(addr) >= int'(A_DUTY0)) && (int'(addr) < int'(A_DUTY0) + NCH);
        is_known = is_freq || is_duty || addr == A_MODE || addr == A_LEVEL
                   || addr == A_ERR || addr == A_VER;
        duty_ok = 1'b1;
        for (int c = 0; c < NCH; c++)
            if (int'(duty_q[c]) > DUTY_FULL) duty_ok = 1'b0;
    end

    // R7
    freq_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_freq && int'(wdata) > FREQ_MAX) |=> (err_q == 2'd1 && $stable(freq_q)));

    // R8
    duty_clamp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_duty && int'(wdata) > DUTY_FULL) |=> err_q == 2'd2);

    // R8
    duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n) duty_ok);

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ERR && wdata == '0) |=> err_q == 2'd0);

    // R10
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_known) |=> ($stable(err_q) && $stable(freq_q) && $stable(duty_q)));

    for (genvar g = 0; g < NGRP; g++) begin : g_stop
        // R5
        stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(A_FREQ0 + g) && wdata == '0)
            |=> pwm_raw[g*GRP_SZ +: GRP_SZ] == '0);
    end
endmodule

bind pwm_grouped pwm_grouped_chk #(
    .NGRP(NGRP), .GRP_SZ(GRP_SZ), .FREQ_MAX(FREQ_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .err_q(err_q), .freq_q(freq_q), .duty_q(duty_q), .pwm_raw(pwm_raw)
);

// File: tb/tb_pwm_grouped.sv
// Bench: sweeps duty and frequency over all twelve channels with a small
// clock rate so periods are a few tens of cycles; expectations computed.
module tb_pwm_grouped;
    localparam int CLK_HZ = 20000;
    localparam int STEP   = CLK_HZ / 1000;
    localparam int NCH    = 12;
    localparam logic [15:0] VER = 16'h0102;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [5:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    int cnt [NCH];
    int duty_v [NCH];
    int fr [3];
    logic [15:0] rv;

    pwm_grouped #(.CLK_HZ(CLK_HZ), .VERSION(VER)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic measure(int cycles);
        for (int c = 0; c < NCH; c++) cnt[c] = 0;
        repeat (cycles) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) cnt[c] += int'(pwm_out[c]);
        end
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One sweep: program freqs, run rounds of duties, count high clocks.
    task automatic sweep(int f0, int f1, int f2, int window, int rounds);
        fr[0] = f0; fr[1] = f1; fr[2] = f2;
        for (int g = 0; g < 3; g++) wr(6'(1 + g), 16'(fr[g]));
        for (int r = 0; r < rounds; r++) begin
            for (int c = 0; c < NCH; c++) begin
                duty_v[c] = (r == 0) ? 0 : (r == 1) ? 1000 : (c * 83 + r * 271) % 1001;
                wr(6'(10 + c), 16'(duty_v[c]));
            end
            repeat (window + 10) @(negedge clk);
            measure(window);
            for (int c = 0; c < NCH; c++) begin
                int f, per, hi;
                f   = fr[c / 4];
                per = CLK_HZ / f;
                hi  = (duty_v[c] * STEP + f - 1) / f;
                // R3 R4: high clocks over whole periods
                chk($sformatf("R4 ch%0d f=%0d d=%0d", c + 1, f, duty_v[c]),
                    cnt[c], (window / per) * hi);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pins", int'(pwm_out), 0);
        rst_n = 1;
        rd(6'h09, rv); chk("R1 err", int'(rv), 0);
        rd(6'h00, rv); chk("R1 mode", int'(rv), 0);
        rd(6'h0A, rv); chk("R1 duty", int'(rv), 0);
        chk("R1 pins after", int'(pwm_out), 0);

        // R2 R11: static levels with all channels in level mode
        wr(6'h04, 16'h0A5C);
        chk("R11 not yet", int'(pwm_out), 0);
        @(negedge clk);
        chk("R2 R11 level", int'(pwm_out), 'hA5C);

        // R2: mode bits 12..15 dropped
        wr(6'h00, 16'hFFFF);
        rd(6'h00, rv); chk("R2 mode width", int'(rv), 'hFFF);

        // R3 R4: grouped sweeps
        sweep(500, 1000, 4000, 80, 6);
        sweep(250, 2000, 1000, 160, 4);

        // R5: stop group 2 with nonzero duties
        for (int c = 4; c < 8; c++) wr(6'(10 + c), 16'd600);
        wr(6'h02, 16'd0);
        measure(40);
        for (int c = 4; c < 8; c++) chk($sformatf("R5 stopped ch%0d", c + 1), cnt[c], 0);

        // R2: mixed modes; group 2 PWM at full duty, others from level
        wr(6'h02, 16'd1000);
        for (int c = 4; c < 8; c++) wr(6'(10 + c), 16'd1000);
        wr(6'h04, 16'h000F);
        wr(6'h00, 16'hF0F0);
        repeat (30) @(negedge clk);
        chk("R2 mixed", int'(pwm_out), 'h0FF);
        rd(6'h00, rv); chk("R2 mode read", int'(rv), 'h0F0);

        // R6: boundary-aligned duty update on channel 1
        wr(6'h00, 16'h0FFF);
        wr(6'h01, 16'd0);
        wr(6'h0A, 16'd0);
        repeat (3) @(negedge clk);
        wr(6'h01, 16'd1000);           // restart, boundary 20 clocks later
        repeat (4) @(negedge clk);
        wr_en = 1; addr = 6'h0A; wdata = 16'd1000;
        @(negedge clk);
        wr_en = 0;
        repeat (10) @(negedge clk);
        chk("R6 mid period", int'(pwm_out[0]), 0);
        repeat (5) @(negedge clk);
        chk("R6 boundary clock", int'(pwm_out[0]), 0);
        @(negedge clk);
        chk("R6 after boundary", int'(pwm_out[0]), 1);

        // R7: frequency above limit discarded
        wr(6'h01, 16'd5000);
        rd(6'h01, rv); chk("R7 freq kept", int'(rv), 1000);
        rd(6'h09, rv); chk("R7 err", int'(rv), 1);

        // R9: nonzero write ignored, zero clears
        wr(6'h09, 16'd7);
        rd(6'h09, rv); chk("R9 hold", int'(rv), 1);
        wr(6'h09, 16'd0);
        rd(6'h09, rv); chk("R9 clear", int'(rv), 0);

        // R8: duty clamp
        wr(6'h0D, 16'd1500);
        rd(6'h0D, rv); chk("R8 clamp", int'(rv), 1000);
        rd(6'h09, rv); chk("R8 err", int'(rv), 2);
        wr(6'h0D, 16'd1000);
        rd(6'h0D, rv); chk("R8 edge 1000", int'(rv), 1000);
        wr(6'h09, 16'd0);
        wr(6'h01, 16'd4000);
        rd(6'h09, rv); chk("R7 edge max", int'(rv), 0);
        rd(6'h01, rv); chk("R7 max stored", int'(rv), 4000);

        // R10: version and reserved space
        rd(6'h3F, rv); chk("R10 version", int'(rv), int'(VER));
        wr(6'h3F, 16'h0000);
        rd(6'h3F, rv); chk("R10 version ro", int'(rv), int'(VER));
        wr(6'h20, 16'hFFFF);
        rd(6'h20, rv); chk("R10 reserved", int'(rv), 0);
        wr(6'h16, 16'd5);
        rd(6'h16, rv); chk("R10 reserved 16", int'(rv), 0);
        rd(6'h09, rv); chk("R10 err untouched", int'(rv), 0);
        rd(6'h15, rv); chk("R10 last duty untouched", int'(rv), duty_v[11]);

        report();
    end
endmodule